// File: doc/BRIEF.md
# DVMA Address Translator

This block turns 32-bit device virtual addresses into 41-bit physical addresses. Translation entries sit in a linear table in an external synchronous memory. A small control register sets four things: the enable bit, a diagnostic flag, the page-size selector and a 3-bit table-size code. The table-size code fixes a window that ends at the top of the 32-bit space and doubles in size with each code step. Only addresses inside this window are translated.

Each request is accepted with a valid/ready handshake, and the control settings are captured at that moment. The block then reads one 64-bit entry, indexed by the page offset from the window base, through a read port with one cycle of latency. The answer comes back on a second valid/ready channel. It is either a physical address with cacheable and streamable attributes, or a 3-bit fault code. Only one request is in flight at a time.

Fault codes: 0 none, 1 address below window, 2 entry not valid, 3 write to read-only page, 4 entry marks a large page, 5 control register selects large pages.

Top module: `dvma_xlate`

## Requirements
- R1: The control register resets to zero. It keeps enable in bit 0, the diagnostic flag in bit 1, the page-size select in bit 2 and the table-size code in bits 18:16. Every other bit reads back as zero on `cfgQ`.
- R2: With enable clear, the response carries the address zero-extended to 41 bits, fault 0, and both attributes low. No table read is issued.
- R3: With enable set, the window base for code n is 2^32 minus (8 MB << n). An address below the base returns fault 1 and issues no table read.
- R4: For an address in the window, exactly one read is issued, with `memRdIdx` = (address − base) >> 13. This index is always below 1024 << n.
- R5: A usable entry gives the physical address {entry[40:13], va[12:0]}. Cacheable comes from entry bit 4 and streamable from entry bit 60, with fault 0.
- R6: An entry whose bit 63 is clear returns fault 2. This takes priority over every other entry check.
- R7: A write request to an entry whose bit 1 is clear returns fault 3. A read request to the same entry translates normally.
- R8: A valid entry with bit 61 set returns fault 4. This takes priority over the write-permission check.
- R9: With enable set and page-size select at 1, every request returns fault 5 and issues no table read.
- R10: The response becomes valid on the second clock edge after the accepting edge. `reqReady` stays low from the accept until the response is taken. The response holds steady while `rspReady` is low.
- R11: A control register write made while a request is in flight does not change that request's result. It applies from the next accepted request onward.
- R12: Any faulted response drives a physical address of zero and both attributes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Control register write strobe |
| cfgWdata | input | 32 | Control register write data |
| cfgQ | output | 32 | Control register contents |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Block can accept a request |
| reqVa | input | 32 | Device virtual address |
| reqWrite | input | 1 | Request is a write access |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Consumer takes the response |
| rspPa | output | 41 | Physical address |
| rspCache | output | 1 | Cacheable attribute |
| rspStream | output | 1 | Streamable attribute |
| rspFault | output | 3 | Fault code |
| memRdEn | output | 1 | Table read strobe |
| memRdIdx | output | 17 | Table entry index |
| memRdData | input | 64 | Entry returned one cycle after the strobe |

## Verification
The hardest case to reach is a control register write that lands while a translation is between its capture and its evaluation. The bench gets there by driving the write on the falling edge just after the accepting edge, so the register changes while the entry read is outstanding. It then compares the result against the old settings. Fault priority needs an entry that is invalid, large-page and read-only all at once. The table model builds entries from residues of the index modulo 7, 11 and 3, so the full sweep of a 1024-entry table reaches every mix of these bits. Each window boundary is probed one byte below the base, at the base and at the last byte.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
  localparam int VA_W        = 32;
  localparam int PAGE_SHIFT  = 13;
  localparam int MIN_ENT_LOG = 10;
  localparam int CODE_W      = 3;
  localparam int ENT_W       = 64;
  localparam int PPN_HI      = 40;
  localparam int PA_W        = PPN_HI + 1;
  localparam int IDX_W       = MIN_ENT_LOG + (1 << CODE_W) - 1;

  // entry bit positions
  localparam int E_VALID  = 63;
  localparam int E_BIGPG  = 61;
  localparam int E_STREAM = 60;
  localparam int E_CACHE  = 4;
  localparam int E_WRITE  = 1;

  // control register bit positions
  localparam int C_EN    = 0;
  localparam int C_DIAG  = 1;
  localparam int C_PGSEL = 2;
  localparam int C_CODE  = 16;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_RANGE   = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_PROT    = 3'd3,
    FLT_SIZE    = 3'd4,
    FLT_PGCFG   = 3'd5
  } fault_t;

  typedef struct packed {
    logic capture;
    logic evaluate;
  } strobe_t;
endpackage

// File: rtl/dvma_ctrl.sv
module dvma_ctrl
  import dvma_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  output logic    rspValid,
  input  logic    rspReady,
  input  logic    needRead,
  output logic    memRdEn,
  output strobe_t strobe
);
  typedef enum logic [1:0] {S_IDLE, S_LOOKUP, S_CHECK, S_RESP} state_t;
  state_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:   if (reqValid) stateNext = S_LOOKUP;
      S_LOOKUP: stateNext = S_CHECK;
      S_CHECK:  stateNext = S_RESP;
      S_RESP:   if (rspReady) stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign reqReady        = (state == S_IDLE);
  assign rspValid        = (state == S_RESP);
  assign memRdEn         = (state == S_LOOKUP) && needRead;
  assign strobe.capture  = (state == S_IDLE) && reqValid;
  assign strobe.evaluate = (state == S_CHECK);

  AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |-> !rspValid); // R10
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid); // R10
  AST_READ_THEN_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (!rspValid && !reqReady)); // R10
endmodule

// File: rtl/dvma_dpath.sv
module dvma_dpath
  import dvma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              cfgWe,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgQ,
  input  logic [VA_W-1:0]   reqVa,
  input  logic              reqWrite,
  output logic              needRead,
  output logic [IDX_W-1:0]  memRdIdx,
  input  logic [ENT_W-1:0]  memRdData,
  input  logic              memRdEn,
  input  logic              rspValid,
  input  logic              rspReady,
  output logic [PA_W-1:0]   rspPa,
  output logic              rspCache,
  output logic              rspStream,
  output fault_t            rspFault
);
  localparam logic [VA_W-1:0] BASE0 = {VA_W{1'b1}} << (PAGE_SHIFT + MIN_ENT_LOG);

  // control register
  logic              ctrlEn, ctrlDiag, ctrlPg;
  logic [CODE_W-1:0] ctrlCode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn <= 1'b0; ctrlDiag <= 1'b0; ctrlPg <= 1'b0; ctrlCode <= '0;
    end else if (cfgWe) begin
      ctrlEn   <= cfgWdata[C_EN];
      ctrlDiag <= cfgWdata[C_DIAG];
      ctrlPg   <= cfgWdata[C_PGSEL];
      ctrlCode <= cfgWdata[C_CODE +: CODE_W];
    end
  end

  always_comb begin
    cfgQ = '0;
    cfgQ[C_EN]             = ctrlEn;
    cfgQ[C_DIAG]           = ctrlDiag;
    cfgQ[C_PGSEL]          = ctrlPg;
    cfgQ[C_CODE +: CODE_W] = ctrlCode;
  end

  // request capture with early checks against the live settings
  logic [VA_W-1:0] winBase, winOff;
  fault_t          earlyNow;
  assign winBase = BASE0 << ctrlCode;
  assign winOff  = reqVa - winBase;

  always_comb begin
    earlyNow = FLT_NONE;
    if (ctrlPg)                 earlyNow = FLT_PGCFG;
    else if (reqVa < winBase)   earlyNow = FLT_RANGE;
  end

  logic [VA_W-1:0]   vaQ;
  logic              wrQ, bypassQ;
  logic [CODE_W-1:0] codeQ;
  fault_t            earlyQ;
  logic [IDX_W-1:0]  idxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ <= '0; wrQ <= 1'b0; bypassQ <= 1'b1; codeQ <= '0;
      earlyQ <= FLT_NONE; idxQ <= '0;
    end else if (strobe.capture) begin
      vaQ     <= reqVa;
      wrQ     <= reqWrite;
      bypassQ <= !ctrlEn;
      codeQ   <= ctrlCode;
      earlyQ  <= earlyNow;
      idxQ    <= winOff[PAGE_SHIFT +: IDX_W];
    end
  end

  assign needRead = !bypassQ && (earlyQ == FLT_NONE);
  assign memRdIdx = idxQ;

  // entry evaluation
  logic [PA_W-1:0] paNext;
  logic            cacheNext, streamNext;
  fault_t          faultNext;

  always_comb begin
    paNext = '0; cacheNext = 1'b0; streamNext = 1'b0; faultNext = FLT_NONE;
    if (bypassQ) begin
      paNext = PA_W'(vaQ);
    end else if (earlyQ != FLT_NONE) begin
      faultNext = earlyQ;
    end else if (!memRdData[E_VALID]) begin
      faultNext = FLT_INVALID;
    end else if (memRdData[E_BIGPG]) begin
      faultNext = FLT_SIZE;
    end else if (wrQ && !memRdData[E_WRITE]) begin
      faultNext = FLT_PROT;
    end else begin
      paNext     = {memRdData[PPN_HI:PAGE_SHIFT], vaQ[PAGE_SHIFT-1:0]};
      cacheNext  = memRdData[E_CACHE];
      streamNext = memRdData[E_STREAM];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPa <= '0; rspCache <= 1'b0; rspStream <= 1'b0; rspFault <= FLT_NONE;
    end else if (strobe.evaluate) begin
      rspPa     <= paNext;
      rspCache  <= cacheNext;
      rspStream <= streamNext;
      rspFault  <= faultNext;
    end
  end

  logic [IDX_W:0] tblEntries;
  assign tblEntries = (IDX_W+1)'(1) << (MIN_ENT_LOG + int'(codeQ));

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> ({1'b0, memRdIdx} < tblEntries)); // R4
  AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && bypassQ) |-> (rspFault == FLT_NONE && rspPa[PA_W-1:VA_W] == '0)); // R2
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != FLT_NONE) |-> (rspPa == '0 && !rspCache && !rspStream)); // R12
  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> ($stable(rspPa) && $stable(rspFault))); // R10
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
  import dvma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgQ,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVa,
  input  logic              reqWrite,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [PA_W-1:0]   rspPa,
  output logic              rspCache,
  output logic              rspStream,
  output logic [2:0]        rspFault,
  output logic              memRdEn,
  output logic [IDX_W-1:0]  memRdIdx,
  input  logic [ENT_W-1:0]  memRdData
);
  strobe_t strobe;
  logic    needRead;
  fault_t  faultQ;

  dvma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .rspValid(rspValid), .rspReady(rspReady),
    .needRead(needRead), .memRdEn(memRdEn), .strobe(strobe)
  );

  dvma_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgQ(cfgQ),
    .reqVa(reqVa), .reqWrite(reqWrite),
    .needRead(needRead), .memRdIdx(memRdIdx), .memRdData(memRdData),
    .memRdEn(memRdEn), .rspValid(rspValid), .rspReady(rspReady),
    .rspPa(rspPa), .rspCache(rspCache), .rspStream(rspStream), .rspFault(faultQ)
  );

  assign rspFault = faultQ;
endmodule

// File: tb/dvma_xlate_bench.sv
module dvma_xlate_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgQ;
  logic        reqValid = 1'b0, reqReady, reqWrite = 1'b0;
  logic [31:0] reqVa = '0;
  logic        rspValid, rspReady = 1'b1, rspCache, rspStream;
  logic [40:0] rspPa;
  logic [2:0]  rspFault;
  logic        memRdEn;
  logic [16:0] memRdIdx;
  logic [63:0] memRdData = '0;

  int checks = 0, errors = 0, rdCount = 0;
  logic [31:0] cfgShadow = '0;

  always #4 clk = ~clk;

  dvma_xlate u_dvma_xlate (.*);

  function automatic logic [63:0] entryFn(input logic [16:0] idx);
    int unsigned i = idx;
    logic [63:0] e = '0;
    e[63]    = (i % 7) != 3;
    e[61]    = (i % 11) == 5;
    e[60]    = idx[1];
    e[59]    = idx[2];
    e[40:13] = 28'(i * 37 + 32'h000ABCDE);
    e[12:5]  = idx[7:0];
    e[4]     = idx[0];
    e[1]     = (i % 3) != 0;
    e[0]     = idx[3];
    return e;
  endfunction

  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= entryFn(memRdIdx);
      rdCount   <= rdCount + 1;
    end
  end

  function automatic logic [31:0] baseOf(input logic [2:0] code);
    logic [32:0] size = 33'h000800000 << code;
    return 32'(33'h100000000 - size);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [31:0] d);
    @(negedge clk); cfgWe = 1'b1; cfgWdata = d;
    @(negedge clk); cfgWe = 1'b0;
    cfgShadow = d & 32'h0007_0007;
  endtask

  // one translation; optional mid-flight control write and response hold
  task automatic doReq(input logic [31:0] va, input logic wr, input string req,
                       input bit midCfg = 0, input logic [31:0] midData = '0,
                       input int hold = 0);
    logic [40:0] ePa = '0; logic eC = 0, eS = 0; logic [2:0] eF = 0;
    int eRd = 0; logic [16:0] eIdx = '0; logic [63:0] e;
    logic [31:0] base = baseOf(cfgShadow[18:16]);
    int rd0; logic sawRd; logic [16:0] sawIdx;
    if (!cfgShadow[0]) ePa = {9'd0, va};
    else if (cfgShadow[2]) eF = 5;
    else if (va < base) eF = 1;
    else begin
      eRd = 1; eIdx = 17'((va - base) / 8192); e = entryFn(eIdx);
      if (!e[63]) eF = 2;
      else if (e[61]) eF = 4;
      else if (wr && !e[1]) eF = 3;
      else begin ePa = {e[40:13], va[12:0]}; eC = e[4]; eS = e[60]; end
    end
    @(negedge clk); reqVa = va; reqWrite = wr; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    rd0 = rdCount;
    @(negedge clk); reqValid = 1'b0; sawRd = memRdEn; sawIdx = memRdIdx;
    if (midCfg) begin cfgWe = 1'b1; cfgWdata = midData; end
    if (rspValid) check(0, "R10", "early response", 1, 0);
    @(negedge clk); cfgWe = 1'b0;
    if (hold > 0) rspReady = 1'b0;
    if (rspValid) check(0, "R10", "response after one edge", 1, 0);
    @(negedge clk);
    check(rspValid === 1'b1, "R10", "response on second edge", 64'(rspValid), 1);
    check({rspPa, rspCache, rspStream, rspFault} === {ePa, eC, eS, eF}, req,
          $sformatf("va %h wr %0d pa/c/s/f", va, wr),
          64'({rspPa, rspCache, rspStream, rspFault}), 64'({ePa, eC, eS, eF}));
    check((rdCount - rd0) == eRd && sawRd == (eRd == 1), "R4", "table read count",
          64'(rdCount - rd0), 64'(eRd));
    if (eRd == 1) check(sawIdx === eIdx, "R4", "entry index", 64'(sawIdx), 64'(eIdx));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(rspValid && !reqReady && rspPa === ePa && rspFault === eF, "R10",
            "held response", 64'(rspPa), 64'(ePa));
    end
    rspReady = 1'b1;
    if (midCfg) cfgShadow = midData & 32'h0007_0007;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cfgQ === 32'h0 && reqReady && !rspValid, "R1", "reset state",
          64'(cfgQ), 0);
    writeCfg(32'hFFFF_FFFF);
    check(cfgQ === 32'h0007_0007, "R1", "field mask", 64'(cfgQ), 64'h0007_0007);
    writeCfg(32'h0005_0002);
    check(cfgQ === 32'h0005_0002, "R1", "code and diag", 64'(cfgQ), 64'h0005_0002);

    // R2 pass-through with enable clear
    writeCfg(32'h0003_0000);
    doReq(32'h0000_0000, 0, "R2");
    doReq(32'hFFFF_FFFF, 1, "R2");
    doReq(32'h1234_5678, 0, "R2");

    // R9 large-page control selection
    writeCfg(32'h0000_0005);
    doReq(32'hFF80_0000, 0, "R9");
    doReq(32'hFFFF_E000, 1, "R9");

    // full sweep of the smallest table: R5 R6 R7 R8 R12
    writeCfg(32'h0000_0001);
    for (int p = 0; p < 1024; p++) begin
      doReq(baseOf(0) + 32'(p) * 8192 + 32'(p * 53 % 8192), 0, "R5/R6/R8 r12_");
      doReq(baseOf(0) + 32'(p) * 8192 + 32'((p * 97 + 11) % 8192), 1, "R7 r12_");
    end

    // every table size: window edges and spread pages (R3 R4)
    for (int c = 0; c < 8; c++) begin
      logic [31:0] b = baseOf(3'(c));
      writeCfg(32'(c) << 16 | 32'h1);
      doReq(b - 1, 0, "R3");
      doReq(32'h0000_0000, 1, "R3");
      doReq(b, 0, "R3");
      doReq(32'hFFFF_FFFF, 0, "R3");
      for (int k = 0; k < 24; k++)
        doReq(b + 32'((k * 40503 + 7) % (1024 << c)) * 8192 + 32'(k * 331), k[0], "R4");
    end

    // R10 held response
    writeCfg(32'h0002_0001);
    doReq(baseOf(2) + 32'd1 * 8192, 0, "R10", 0, '0, 3);
    doReq(32'h0000_1000, 0, "R10", 0, '0, 2);

    // R11 control write during flight
    doReq(baseOf(2) + 32'd9 * 8192 + 5, 0, "R11", 1, 32'h0000_0000);
    check(cfgQ === 32'h0, "R11", "new settings stored", 64'(cfgQ), 0);
    doReq(baseOf(2) + 32'd9 * 8192 + 5, 0, "R11");
    writeCfg(32'h0000_0001);
    doReq(32'h0000_4000, 0, "R11", 1, 32'h0007_0001);
    doReq(32'hC000_4000, 0, "R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule